// File: doc/BRIEF.md
# External Interrupt Request Capture

This block turns one external interrupt line into the single request flag that an 8051-style interrupt controller's priority logic reads. The external pin is active low and passes through a multi-flop synchronizer. A mode input selects how the flag behaves. In transition mode, a high-to-low change of the synchronized pin sets the flag, and the CPU's vector-acknowledge pulse clears it. In level mode, the flag tracks the asserted level of the line, and the acknowledge has no effect. As a result, a line that is still low when service ends raises the request again.

A select input hands the interrupt over to an ADC conversion-done pulse. While that source is selected, each one-cycle done pulse acts as an edge event, whatever the mode input says. Software can also write the flag directly through a write-enable and data bit. Priority resolution, vector generation and the CPU core sit outside the block.

Top module: `ext_irq_capture`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `req_flag` is 0. Every synchronizer stage resets to 1, which is the inactive pin level.
- R2: With `mode_edge`=1 and `src_adc_sel`=0, `pin_n` going from 1 to 0 sets `req_flag` on the third rising clock edge after the change (`SYNC_STAGES`+1 edges, default 2 stages). A low pulse one cycle wide is enough.
- R3: With `mode_edge`=1 and no event or software write in the same cycle, `vec_ack`=1 clears `req_flag` at the next edge.
- R4: If a set event and `vec_ack` arrive in the same cycle, the event wins and `req_flag` stays 1.
- R5: With `mode_edge`=0 and `src_adc_sel`=0, `req_flag` at each edge takes the inverted synchronized pin, so it changes `SYNC_STAGES`+1 edges after `pin_n` does. `vec_ack` has no effect in this mode.
- R6: `sw_we`=1 loads `sw_wdata` into `req_flag` at the next edge (1 sets, 0 clears), unless a set event arrives in the same cycle. In level mode the written value lasts one cycle, after which the flag follows the line again.
- R7: With `src_adc_sel`=1, a one-cycle `adc_done` pulse sets `req_flag` at the next edge and `vec_ack` clears it. `pin_n` and `mode_edge` are then ignored.
- R8: In transition mode, a rising change of `pin_n` never sets `req_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | 1 | External interrupt line, active low, asynchronous |
| adc_done | input | 1 | Conversion-done pulse, one cycle, synchronous |
| src_adc_sel | input | 1 | 1 selects the ADC pulse as the source, 0 selects the pin |
| mode_edge | input | 1 | 0 = level-active, 1 = transition-active |
| vec_ack | input | 1 | CPU vector-acknowledge pulse |
| sw_we | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Value written to the flag |
| req_flag | output | 1 | Interrupt request flag toward the priority logic |

## Verification
The synchronizer, the edge memory and the flag are the only state in the block, and each is visible at `req_flag` within `SYNC_STAGES`+1 edges. A wrong stage or edge-memory value shows up as a missing, early or duplicated set after a pin fall. A flag that mishandles acknowledge or software write is wrong on the very next edge. The bench walks the pin through falls, rises and held-low periods. It also lines up events with acknowledges and writes in the same cycle, and it switches source and mode to show that what they deselect is ignored.

// File: rtl/ext_irq_capture_pkg.sv
package ext_irq_capture_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_mode_e;

   typedef struct packed {
      logic set_evt;
      logic line_act;
      logic pulse_mode;
   } flag_ctl_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int   STAGES    = 2,
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eirq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [LAST:0] stage_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_LEVEL;
               else        stage_q[s] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_LEVEL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/eirq_fall_detect.sv
module eirq_fall_detect #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= level_i;
   end

   assign fall_o = prev_q & ~level_i;

   // a fall needs a high sample before it, so two in a row cannot occur
   AST_FALL_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o); // R8

endmodule

// File: rtl/eirq_flag.sv
module eirq_flag
   import ext_irq_capture_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_ctl_t ctl_i,
   input  logic      ack_i,
   input  logic      we_i,
   input  logic      wdata_i,
   output logic      flag_o
);

   logic flag_q;
   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (ctl_i.pulse_mode) begin
         if (ctl_i.set_evt)  flag_d = 1'b1;
         else if (we_i)      flag_d = wdata_i;
         else if (ack_i)     flag_d = 1'b0;
      end else begin
         if (we_i)           flag_d = wdata_i;
         else                flag_d = ctl_i.line_act;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

   AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.pulse_mode && ctl_i.set_evt) |=> flag_o); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_i.pulse_mode && ack_i && !ctl_i.set_evt && !we_i) |=> !flag_o); // R3

   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !(ctl_i.pulse_mode && ctl_i.set_evt)) |=> (flag_o == $past(wdata_i))); // R6

   AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_i.pulse_mode && !we_i && ctl_i.line_act) |=> flag_o); // R5

endmodule

// File: rtl/ext_irq_capture.sv
module ext_irq_capture
   import ext_irq_capture_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit ADC_TAKEOVER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic adc_done,
   input  logic src_adc_sel,
   input  logic mode_edge,
   input  logic vec_ack,
   input  logic sw_we,
   input  logic sw_wdata,
   output logic req_flag
);

   localparam logic PIN_IDLE = 1'b1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_cfg
         $error("ext_irq_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       pin_sync;
   logic       pin_fall;
   logic       use_adc;
   trig_mode_e trig;
   flag_ctl_t  ctl;

   eirq_sync #(
      .STAGES    (SYNC_STAGES),
      .RST_LEVEL (PIN_IDLE)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_n),
      .sync_o  (pin_sync)
   );

   eirq_fall_detect #(
      .IDLE_LEVEL (PIN_IDLE)
   ) i_fall (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (pin_sync),
      .fall_o  (pin_fall)
   );

   assign trig = trig_mode_e'(mode_edge);

   generate
      if (ADC_TAKEOVER) begin : g_adc_mux
         assign use_adc = src_adc_sel;
         always_comb begin
            ctl.pulse_mode = use_adc | (trig == TRIG_EDGE);
            ctl.set_evt    = use_adc ? adc_done : pin_fall;
            ctl.line_act   = ~pin_sync;
         end
      end else begin : g_pin_only
         assign use_adc = 1'b0;
         always_comb begin
            ctl.pulse_mode = (trig == TRIG_EDGE);
            ctl.set_evt    = pin_fall;
            ctl.line_act   = ~pin_sync;
         end
      end
   endgenerate

   eirq_flag i_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_i   (ctl),
      .ack_i   (vec_ack),
      .we_i    (sw_we),
      .wdata_i (sw_wdata),
      .flag_o  (req_flag)
   );

   AST_ADC_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (use_adc && !adc_done && !sw_we && !req_flag) |=> !req_flag); // R7

   AST_ADC_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (use_adc && adc_done) |=> req_flag); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> !req_flag); // R1

endmodule

// File: tb/test_ext_irq_capture.sv
module test_ext_irq_capture;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_n = 1'b1;
   logic adc_done = 1'b0;
   logic src_adc_sel = 1'b0;
   logic mode_edge = 1'b1;
   logic vec_ack = 1'b0;
   logic sw_we = 1'b0;
   logic sw_wdata = 1'b0;
   logic req_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ext_irq_capture i_ext_irq_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_n       (pin_n),
      .adc_done    (adc_done),
      .src_adc_sel (src_adc_sel),
      .mode_edge   (mode_edge),
      .vec_ack     (vec_ack),
      .sw_we       (sw_we),
      .sw_wdata    (sw_wdata),
      .req_flag    (req_flag)
   );

   // row = {req id, mode_edge, src_adc_sel, pin_n, adc_done, vec_ack, sw_we, sw_wdata, expected flag}
   // expected is the flag after the edge that follows the row's drive
   localparam int NV = 27;
   localparam logic [11:0] VEC [NV] = '{
      {4'd1, 8'b1_0_1_0_0_0_0_0},  // R1 idle after reset
      {4'd2, 8'b1_0_0_0_0_0_0_0},  // R2 pin falls, stage 1
      {4'd2, 8'b1_0_0_0_0_0_0_0},  // R2 stage 2
      {4'd2, 8'b1_0_0_0_0_0_0_1},  // R2 third edge sets
      {4'd3, 8'b1_0_0_0_1_0_0_0},  // R3 ack clears
      {4'd8, 8'b1_0_1_0_0_0_0_0},  // R8 pin rises
      {4'd8, 8'b1_0_1_0_0_0_0_0},  // R8 rise reaches detector, no set
      {4'd2, 8'b1_0_0_0_0_0_0_0},  // R2 second fall
      {4'd2, 8'b1_0_0_0_0_0_0_0},
      {4'd4, 8'b1_0_0_0_1_0_0_1},  // R4 event and ack together
      {4'd6, 8'b1_0_0_0_0_1_0_0},  // R6 write 0
      {4'd6, 8'b1_0_0_0_0_1_1_1},  // R6 write 1
      {4'd6, 8'b1_0_0_0_0_0_0_1},  // R6 holds
      {4'd5, 8'b0_0_0_0_0_0_0_1},  // R5 level, line low
      {4'd5, 8'b0_0_0_0_1_0_0_1},  // R5 ack ignored
      {4'd5, 8'b0_0_1_0_0_0_0_1},  // R5 pin rises, still in sync
      {4'd5, 8'b0_0_1_0_0_0_0_1},
      {4'd5, 8'b0_0_1_0_0_0_0_0},  // R5 flag drops
      {4'd6, 8'b0_0_1_0_0_1_1_1},  // R6 level-mode write lasts one cycle
      {4'd6, 8'b0_0_1_0_0_0_0_0},
      {4'd7, 8'b1_1_1_0_0_0_0_0},  // R7 ADC source idle
      {4'd7, 8'b1_1_0_1_0_0_0_1},  // R7 done pulse sets
      {4'd7, 8'b1_1_0_0_1_0_0_0},  // R7 ack clears
      {4'd7, 8'b1_1_0_0_0_0_0_0},  // R7 pin fall ignored
      {4'd7, 8'b0_1_0_0_0_0_0_0},  // R7 mode ignored, low pin ignored
      {4'd7, 8'b0_1_0_1_0_0_0_1},
      {4'd7, 8'b0_1_0_0_1_0_0_0}
   };

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: req_flag=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1", req_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", req_flag, 1'b0);

      for (int i = 0; i < NV; i++) begin
         mode_edge   = VEC[i][7];
         src_adc_sel = VEC[i][6];
         pin_n       = VEC[i][5];
         adc_done    = VEC[i][4];
         vec_ack     = VEC[i][3];
         sw_we       = VEC[i][2];
         sw_wdata    = VEC[i][1];
         @(negedge clk);
         check($sformatf("R%0d row %0d", VEC[i][11:8], i), req_flag, VEC[i][0]);
      end

      adc_done = 1'b0; vec_ack = 1'b0; sw_we = 1'b0;
      src_adc_sel = 1'b0; mode_edge = 1'b1; pin_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R3 idle edge mode", req_flag, 1'b0);

      // R2 single-cycle low pulse is caught
      pin_n = 1'b0;
      @(negedge clk);
      pin_n = 1'b1;
      @(negedge clk);
      check("R2 short pulse not yet", req_flag, 1'b0);
      @(negedge clk);
      check("R2 short pulse sets", req_flag, 1'b1);

      // R1 reset in mid-operation clears a set flag
      rst_n = 1'b0;
      #1;
      check("R1 async reset", req_flag, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", req_flag, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule